// File: doc/BRIEF.md
# Programmable One-Shot / Periodic Interval Timer Channel

This block is a single countdown timer channel advanced by an external tick strobe. The tick is normally one pulse per microsecond. Software programs it through two 32-bit registers on a small local bus. The load register holds an enable flag, a mode flag and a count field. Writing it starts a fresh countdown. The counter loses one step on each enabled tick. When an enabled tick arrives with the counter already at zero, the countdown expires. A programmed count of n therefore expires on the (n+1)-th tick.

On expiry the channel sets a level-high interrupt, which stays set until software acknowledges it. In one-shot mode the channel then turns its own enable flag off. In periodic mode it reloads the programmed count and keeps counting. The acknowledge/status register clears the interrupt through a write-one bit. Reads of the same register return the pending flag and the remaining count. Channels are meant to be stacked at an 8-byte stride, so only the local offsets 0x0 and 0x4 are decoded here.

Top module: `tmr_channel`

## Requirements
- R1: After synchronous reset the channel is disabled, the interrupt is low, and both registers read as zero.
- R2: A write to offset 0x0 programs the load register: bit 31 is enable, bit 30 selects periodic mode (1) or one-shot (0), and bits CNT_W-1:0 are the count. A read of offset 0x0 returns exactly those fields, with every other bit zero.
- R3: With a programmed count n and the channel enabled, the interrupt rises in the cycle after the (n+1)-th tick and not before. A count of 0 expires on the first tick.
- R4: The all-ones count (2^CNT_W - 1) expires after exactly 2^CNT_W ticks.
- R5: On a one-shot expiry, bit 31 of the load register reads back 0 and further ticks raise no new expiry.
- R6: In periodic mode every expiry reloads the programmed count, so expiries recur every n+1 ticks while the enable bit stays 1.
- R7: Writing zero to offset 0x0 disables the channel and cancels the countdown, and later ticks raise no interrupt.
- R8: Any write to offset 0x0 restarts the countdown from the newly written count. A tick in the same cycle as that write is not counted.
- R9: The interrupt is active high and stays set until a write to offset 0x4 with bit 30 set. A write to offset 0x4 with bit 30 clear leaves it unchanged.
- R10: If an expiry and an acknowledge write fall in the same cycle, the interrupt stays set.
- R11: A read of offset 0x4 returns the remaining count in bits CNT_W-1:0 and the pending interrupt flag in bit 30. All other bits read zero.
- R12: Ticks arriving while the channel is disabled leave the remaining count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle count strobe |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe (with select) |
| bus_addr_i | input | ADDR_W | Local byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, zero when not selected |
| irq_o | output | 1 | Level-high interrupt |

## Verification
The bench builds the channel with CNT_W = 8 and ADDR_W = 3. The narrower count field makes the all-ones count reachable: the full 256-tick countdown runs alongside the short counts, and the register layout stays the same as at 29 bits. A 3-bit offset also reaches the unused offsets, so reads there can be checked for zero. Random sequences mix loads, acknowledges and ticks in the same cycle, which exercises the write-versus-tick and expiry-versus-acknowledge orderings many times.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W   = 32;
    localparam int EN_BIT   = 31;
    localparam int PER_BIT  = 30;
    localparam int ACK_BIT  = 30;
    localparam int PEND_BIT = 30;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_LOAD,
        CMD_ACK
    } bus_cmd_e;

    typedef struct packed {
        logic en;
        logic per;
    } mode_t;

    function automatic mode_t mode_of(input logic [DATA_W-1:0] w);
        mode_t m;
        m.en  = w[EN_BIT];
        m.per = w[PER_BIT];
        return m;
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int CNT_W   = 29,
    parameter int OFF_LD  = 0,
    parameter int OFF_ACK = 4
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output bus_cmd_e          cmd_o,
    output logic              load_o,
    output logic              ack_o,
    output mode_t             mode_o,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam logic [ADDR_W-1:0] LD_A  = ADDR_W'(OFF_LD);
    localparam logic [ADDR_W-1:0] ACK_A = ADDR_W'(OFF_ACK);

    always_comb begin
        cmd_o = CMD_IDLE;
        if (sel_i && wr_i) begin
            if (addr_i == LD_A)
                cmd_o = CMD_LOAD;
            else if (addr_i == ACK_A && wdata_i[ACK_BIT])
                cmd_o = CMD_ACK;
        end
    end

    assign load_o = (cmd_o == CMD_LOAD);
    assign ack_o  = (cmd_o == CMD_ACK);
    assign mode_o = mode_of(wdata_i);
    assign cnt_o  = wdata_i[CNT_W-1:0];

endmodule

// File: rtl/tmr_down.sv
module tmr_down
    import tmr_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  mode_t            mode_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             tick_i,
    output mode_t            mode_o,
    output logic [CNT_W-1:0] prog_o,
    output logic [CNT_W-1:0] rem_o,
    output logic             expire_o
);

    mode_t            mode_q;
    logic [CNT_W-1:0] prog_q;
    logic [CNT_W-1:0] rem_q;
    logic             step;
    logic             at_zero;

    assign step     = tick_i && mode_q.en && !load_i;
    assign at_zero  = (rem_q == '0);
    assign expire_o = step && at_zero;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q <= '0;
            prog_q <= '0;
            rem_q  <= '0;
        end else if (load_i) begin
            mode_q <= mode_i;
            prog_q <= cnt_i;
            rem_q  <= cnt_i;
        end else if (step) begin
            if (at_zero) begin
                if (mode_q.per)
                    rem_q <= prog_q;
                else
                    mode_q.en <= 1'b0;
            end else begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    assign mode_o = mode_q;
    assign prog_o = prog_q;
    assign rem_o  = rem_q;

    AST_LOAD_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> rem_q == $past(cnt_i));  // R8
    AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (rst_i)
        (expire_o && !mode_q.per) |=> !mode_q.en);  // R5
    AST_PERIOD_RELOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        (expire_o && mode_q.per) |=> (mode_q.en && rem_q == $past(prog_q)));  // R6
    AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mode_q.en && !load_i) |=> $stable(rem_q));  // R12

endmodule

// File: rtl/tmr_pend.sv
module tmr_pend (
    input  logic clk_i,
    input  logic rst_i,
    input  logic set_i,
    input  logic ack_i,
    output logic pend_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            pend_o <= 1'b0;
        else if (set_i)
            pend_o <= 1'b1;
        else if (ack_i)
            pend_o <= 1'b0;
    end

    AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_o && !ack_i) |=> pend_o);  // R9
    AST_SET_BEATS_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
        set_i |=> pend_o);  // R10
    AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_i && !set_i) |=> !pend_o);  // R9

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 29
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);

    localparam int OFF_LD  = 0;
    localparam int OFF_ACK = 4;
    localparam logic [ADDR_W-1:0] LD_A  = ADDR_W'(OFF_LD);
    localparam logic [ADDR_W-1:0] ACK_A = ADDR_W'(OFF_ACK);

    bus_cmd_e         cmd;
    logic             load;
    logic             ack;
    mode_t            wr_mode;
    logic [CNT_W-1:0] wr_cnt;
    mode_t            cur_mode;
    logic [CNT_W-1:0] prog;
    logic [CNT_W-1:0] rem;
    logic             expire;
    logic             pend;

    tmr_decode #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .OFF_LD (OFF_LD),
        .OFF_ACK(OFF_ACK)
    ) u_decode (
        .sel_i  (bus_sel_i),
        .wr_i   (bus_wr_i),
        .addr_i (bus_addr_i),
        .wdata_i(bus_wdata_i),
        .cmd_o  (cmd),
        .load_o (load),
        .ack_o  (ack),
        .mode_o (wr_mode),
        .cnt_o  (wr_cnt)
    );

    tmr_down #(.CNT_W(CNT_W)) u_down (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (load),
        .mode_i  (wr_mode),
        .cnt_i   (wr_cnt),
        .tick_i  (tick_i),
        .mode_o  (cur_mode),
        .prog_o  (prog),
        .rem_o   (rem),
        .expire_o(expire)
    );

    tmr_pend u_pend (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .set_i (expire),
        .ack_i (ack),
        .pend_o(pend)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i) begin
            if (bus_addr_i == LD_A) begin
                bus_rdata_o[EN_BIT]    = cur_mode.en;
                bus_rdata_o[PER_BIT]   = cur_mode.per;
                bus_rdata_o[CNT_W-1:0] = prog;
            end else if (bus_addr_i == ACK_A) begin
                bus_rdata_o[PEND_BIT]  = pend;
                bus_rdata_o[CNT_W-1:0] = rem;
            end
        end
    end

    assign irq_o = pend;

    AST_EXPIRE_RAISES: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && cur_mode.en && rem == '0 && cmd != CMD_LOAD) |=> irq_o);  // R3
    AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!irq_o && !cur_mode.en) |=> !irq_o);  // R7

endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;

    localparam int PERIOD = 10;
    localparam int CW     = 8;
    localparam int AW     = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          tick;
    logic          sel;
    logic          wr;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic          irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic          m_en, m_per, m_irq;
    logic [CW-1:0] m_prog, m_rem;

    always #(PERIOD/2) clk = ~clk;

    tmr_channel #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .tick_i     (tick),
        .bus_sel_i  (sel),
        .bus_wr_i   (wr),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .irq_o      (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_ld();
        logic [31:0] v = '0;
        v[31] = m_en; v[30] = m_per; v[CW-1:0] = m_prog;
        return v;
    endfunction

    function automatic logic [31:0] exp_ack();
        logic [31:0] v = '0;
        v[30] = m_irq; v[CW-1:0] = m_rem;
        return v;
    endfunction

    task automatic model(input logic w, input logic [AW-1:0] a,
                         input logic [31:0] d, input logic t);
        logic ld, ak, ex;
        ld = w && a == 0;
        ak = w && a == 4 && d[30];
        ex = t && m_en && m_rem == 0 && !ld;
        if (ld) begin
            m_en = d[31]; m_per = d[30]; m_prog = d[CW-1:0]; m_rem = d[CW-1:0];
        end else if (t && m_en) begin
            if (m_rem == 0) begin
                if (m_per) m_rem = m_prog; else m_en = 1'b0;
            end else m_rem = m_rem - 1'b1;
        end
        if (ex) m_irq = 1'b1; else if (ak) m_irq = 1'b0;
    endtask

    task automatic cyc(input logic w, input logic [AW-1:0] a,
                       input logic [31:0] d, input logic t);
        @(negedge clk);
        sel = w; wr = w; addr = a; wdata = d; tick = t;
        @(posedge clk);
        model(w, a, d, t);
        #1;
        sel = 0; wr = 0; tick = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        sel = 1; wr = 0; addr = a;
        #1 d = rdata;
        sel = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 1);
    endtask

    task automatic cmp_all(input string tag);
        logic [31:0] d;
        chk({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
        rd(0, d); chk({tag, " ld"}, d, exp_ld());
        rd(4, d); chk({tag, " ack"}, d, exp_ack());
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(1234));
        rst = 1; tick = 0; sel = 0; wr = 0; addr = 0; wdata = 0;
        m_en = 0; m_per = 0; m_irq = 0; m_prog = 0; m_rem = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 0);
        rd(0, d); chk("R1 ld", d, 0);
        rd(4, d); chk("R1 ack", d, 0);
        rd(2, d); chk("R1 unused offset", d, 0);

        // R2 field layout readback
        cyc(1, 0, 32'hC000_00A5, 0);
        rd(0, d); chk("R2 ld readback", d, 32'hC000_00A5);
        cyc(1, 0, 32'h4FFF_FF13, 0);
        rd(0, d); chk("R2 upper bits dropped", d, 32'h4000_0013);

        // R3 count 3 -> four ticks
        cyc(1, 0, 32'h8000_0003, 0);
        ticks(3);
        chk("R3 no early irq", {31'b0, irq}, 0);
        ticks(1);
        chk("R3 irq after n+1", {31'b0, irq}, 1);
        // R5 one-shot stops
        rd(0, d); chk("R5 enable cleared", d[31], 0);
        cyc(1, 4, 32'h4000_0000, 0);
        ticks(5);
        chk("R5 no re-fire", {31'b0, irq}, 0);

        // R3 count 0 fires on first tick
        cyc(1, 0, 32'h8000_0000, 0);
        ticks(1);
        chk("R3 zero count first tick", {31'b0, irq}, 1);
        // R9 ack bit zero ignored, bit 30 clears
        cyc(1, 4, 32'hBFFF_FFFF, 0);
        chk("R9 ack without bit30", {31'b0, irq}, 1);
        cyc(0, 0, 0, 0);
        chk("R9 level held", {31'b0, irq}, 1);
        cyc(1, 4, 32'h4000_0000, 0);
        chk("R9 acked", {31'b0, irq}, 0);

        // R4 all-ones count
        cyc(1, 0, 32'h8000_00FF, 0);
        ticks(255);
        chk("R4 not yet", {31'b0, irq}, 0);
        ticks(1);
        chk("R4 expired at 2^W", {31'b0, irq}, 1);
        cyc(1, 4, 32'h4000_0000, 0);

        // R6 periodic count 2
        cyc(1, 0, 32'hC000_0002, 0);
        for (int k = 0; k < 3; k++) begin
            ticks(2);
            chk("R6 quiet between", {31'b0, irq}, 0);
            ticks(1);
            chk("R6 periodic expiry", {31'b0, irq}, 1);
            rd(4, d); chk("R6 reloaded", d, 32'h4000_0002);
            cyc(1, 4, 32'h4000_0000, 0);
        end

        // R10 expiry and ack same cycle
        cyc(1, 0, 32'hC000_0000, 0);
        ticks(1);
        cyc(1, 4, 32'h4000_0000, 1);
        chk("R10 expiry beats ack", {31'b0, irq}, 1);
        cyc(1, 4, 32'h4000_0000, 0);
        chk("R10 later ack", {31'b0, irq}, 0);

        // R7 write zero cancels
        cyc(1, 0, 32'h8000_0004, 0);
        ticks(2);
        cyc(1, 0, 32'h0000_0000, 0);
        ticks(10);
        chk("R7 cancelled irq", {31'b0, irq}, 0);
        rd(0, d); chk("R7 ld zero", d, 0);

        // R8 restart, tick in same cycle as load ignored
        cyc(1, 0, 32'h8000_0005, 0);
        ticks(4);
        cyc(1, 0, 32'h8000_0002, 1);
        rd(4, d); chk("R8 restart value", d, 32'h0000_0002);
        ticks(2);
        chk("R8 not yet", {31'b0, irq}, 0);
        ticks(1);
        chk("R8 fired from new count", {31'b0, irq}, 1);
        cyc(1, 4, 32'h4000_0000, 0);

        // R12 disabled ticks
        cyc(1, 0, 32'h0000_0005, 0);
        ticks(7);
        rd(4, d); chk("R12 frozen count", d, 32'h0000_0005);

        // R11 remaining count readback
        cyc(1, 0, 32'h8000_0009, 0);
        ticks(3);
        rd(4, d); chk("R11 remaining", d, 32'h0000_0006);

        // random mix against model (R3 R6 R8 R10 R11)
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [31:0] v;
            op = $urandom_range(0, 99);
            v  = $urandom();
            if ($urandom_range(0, 9) != 0) v[CW-1:0] = CW'($urandom_range(0, 6));
            if (op < 8)       cyc(1, 0, v, $urandom_range(0, 1));
            else if (op < 16) cyc(1, 4, v, $urandom_range(0, 1));
            else if (op < 20) cyc(1, AW'($urandom_range(1, 7)), v, 1);
            else if (op < 80) cyc(0, 0, 0, 1);
            else              cyc(0, 0, 0, 0);
            cmp_all("R11 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule